// File: doc/BRIEF.md
# Cache Fill Controller with Victim Writeback

This block holds the table of outstanding misses for one cache level and retires at most one of them per cycle once its data is back. Each cycle it picks the ready entry and presents that entry's set to an external victim selector. It reads the chosen way of the line store. If that line is valid and dirty, the block sends a writeback request toward the next-lower level. It then installs the returned line, signals the instruction side and/or the data side of the level above, reports the miss latency and frees the tracking entry.

A dirty victim whose writeback cannot be queued blocks the fill. When the lower write queue is full, the entry stays in the table and a stall counter counts every such cycle. The fill completes in the first cycle the queue has room. A fill for a read-for-ownership request installs the line already dirty.

The block's outputs come from registers. They reflect the decision taken at the preceding clock edge and are valid for one cycle. A probe port reads any stored line without side effects.

Top module: `fill_ctrl`

## Requirements
- R1: After synchronous reset, the returned-entry count, the stall count and every output valid (fill_done, wb_valid, up_i_valid, up_d_valid, lat_valid) are 0, and every stored line reads back invalid on the probe port.
- R2: A returned entry is filled only when cur_cycle is greater than or equal to its recorded fill cycle (ret_cycle). One cycle below that value, nothing happens.
- R3: Among valid entries whose data has returned, the one with the smallest fill cycle is filled first, and equal fill cycles go to the lowest index. Entries whose data has not returned are never picked.
- R4: If the picked entry is otherwise ready, the victim line (set = low SET_W bits of the address, way = victim_way) is valid and dirty, and lwq_full is 1, then no fill happens that cycle. The entry stays counted, the stored line is unchanged, and stall_count rises by one for each such cycle.
- R5: A fill whose victim is valid and dirty raises wb_valid for one cycle. wb_addr is {victim tag, set}, wb_data is the victim's data, wb_kind is 3 (writeback), wb_ip is 0 and wb_lvl is the level code LEVEL shifted left by one (4 at the default LEVEL = 2). A clean or invalid victim raises no writeback.
- R6: A fill writes the victim slot as valid, with tag = address bits above the set field and data = ret_data. It is dirty exactly when the request kind is 1 (read-for-ownership). Kinds 0 (load) and 2 (prefetch) install it clean.
- R7: Data goes upward only when the request's fill-level code is below LEVEL. In that case up_i_valid equals the request's instruction-side flag and up_d_valid equals its data-side flag, with up_addr and up_data carrying the line. Otherwise both stay 0.
- R8: lat_valid is 1 on a fill exactly when the entry's enqueue stamp is nonzero, and lat_value is cur_cycle at the fill decision minus that stamp.
- R9: A fill is reported on fill_done and fill_idx one cycle after the decision. The returned-entry count then drops by one and the entry becomes free for a new allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_cycle | input | CYC_W | Current cycle number |
| alloc_en | input | 1 | Create a tracking entry (ignored if the slot is busy) |
| alloc_idx | input | IDX_W | Slot for the new entry |
| alloc_addr | input | ADDR_W | Line address of the miss |
| alloc_kind | input | 2 | 0 load, 1 read-for-ownership, 2 prefetch, 3 writeback |
| alloc_lvl | input | LVL_W | Requested fill-level code |
| alloc_to_i | input | 1 | Return to the instruction side |
| alloc_to_d | input | 1 | Return to the data side |
| alloc_stamp | input | CYC_W | Enqueue cycle, 0 meaning none |
| ret_en | input | 1 | Data for an entry has come back |
| ret_idx | input | IDX_W | Entry the data belongs to |
| ret_data | input | DATA_W | Returned line data |
| ret_cycle | input | CYC_W | Earliest cycle for the fill |
| fill_set | output | SET_W | Set of the picked entry, for the victim selector |
| victim_way | input | WAY_W | Way chosen by the victim selector |
| lwq_full | input | 1 | Lower-level write queue is full |
| fill_done | output | 1 | A fill completed |
| fill_idx | output | IDX_W | Entry that was filled |
| ret_count | output | CNT_W | Entries holding returned data |
| stall_count | output | STALL_W | Cycles lost to a full lower write queue |
| wb_valid | output | 1 | Writeback request valid |
| wb_addr | output | ADDR_W | Victim line address |
| wb_data | output | DATA_W | Victim line data |
| wb_kind | output | 2 | Writeback kind code (3) |
| wb_lvl | output | LVL_W | Destination-level code |
| wb_ip | output | IP_W | Instruction pointer field (always 0) |
| up_i_valid | output | 1 | Data returned to the instruction side |
| up_d_valid | output | 1 | Data returned to the data side |
| up_addr | output | ADDR_W | Address of the returned line |
| up_data | output | DATA_W | Returned line data |
| lat_valid | output | 1 | Miss latency is valid |
| lat_value | output | CYC_W | Miss latency in cycles |
| pb_set | input | SET_W | Probe set |
| pb_way | input | WAY_W | Probe way |
| pb_valid | output | 1 | Probed line valid |
| pb_dirty | output | 1 | Probed line dirty |
| pb_tag | output | TAG_W | Probed line tag |
| pb_data | output | DATA_W | Probed line data |

## Verification
The case that is hardest to bring about is a stalled fill: a dirty victim in the same slot that a pending entry targets, while the lower write queue reports full. The stimulus first runs a read-for-ownership fill into that slot so that it turns dirty. It then returns a second entry aimed at the same way with lwq_full held high for two cycles. It observes the stall count, the unchanged stored line and the held entry count, then releases the queue and checks that the writeback carries the old line. A sweep over every set and way, first with ownership fills and then with clean fills, checks each eviction against a line-store model in the bench. A separate sequence of three pending entries with equal and distinct fill cycles checks the pick order.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_RFO   = 2'd1,
        K_PREF  = 2'd2,
        K_WBACK = 2'd3
    } req_kind_e;

    localparam int LVL_W = 4;

    function automatic logic [LVL_W-1:0] lower_code(input logic [LVL_W-1:0] here);
        return here << 1;
    endfunction

    function automatic logic is_owned(input req_kind_e k);
        return k == K_RFO;
    endfunction

endpackage

// File: rtl/fill_track.sv
module fill_track #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int CYC_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc_en,
    input  logic [IDX_W-1:0]          alloc_idx,
    input  logic [ADDR_W-1:0]         alloc_addr,
    input  fill_pkg::req_kind_e       alloc_kind,
    input  logic [fill_pkg::LVL_W-1:0] alloc_lvl,
    input  logic                      alloc_to_i,
    input  logic                      alloc_to_d,
    input  logic [CYC_W-1:0]          alloc_stamp,
    input  logic                      ret_en,
    input  logic [IDX_W-1:0]          ret_idx,
    input  logic [DATA_W-1:0]         ret_data,
    input  logic [CYC_W-1:0]          ret_cycle,
    input  logic                      clr_en,
    input  logic [IDX_W-1:0]          clr_idx,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [ENTRIES-1:0]        rdy_vec,
    output logic [CYC_W-1:0]          fcyc [ENTRIES],
    output logic [ADDR_W-1:0]         rd_addr,
    output fill_pkg::req_kind_e       rd_kind,
    output logic [fill_pkg::LVL_W-1:0] rd_lvl,
    output logic                      rd_to_i,
    output logic                      rd_to_d,
    output logic [CYC_W-1:0]          rd_stamp,
    output logic [DATA_W-1:0]         rd_data,
    output logic [CNT_W-1:0]          ret_count
);
    typedef struct packed {
        logic [ADDR_W-1:0]          addr;
        fill_pkg::req_kind_e        kind;
        logic [fill_pkg::LVL_W-1:0] lvl;
        logic                       to_i;
        logic                       to_d;
        logic [CYC_W-1:0]           stamp;
        logic [DATA_W-1:0]          data;
        logic [CYC_W-1:0]           fc;
    } ent_t;

    ent_t              ent_q [ENTRIES];
    logic [ENTRIES-1:0] v_q;
    logic [ENTRIES-1:0] r_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               take_alloc;
    logic               take_ret;

    assign take_alloc = alloc_en && !v_q[alloc_idx];
    assign take_ret   = ret_en && v_q[ret_idx] && !r_q[ret_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= '0;
            r_q   <= '0;
            cnt_q <= '0;
        end else begin
            if (take_alloc) begin
                v_q[alloc_idx]         <= 1'b1;
                r_q[alloc_idx]         <= 1'b0;
                ent_q[alloc_idx].addr  <= alloc_addr;
                ent_q[alloc_idx].kind  <= alloc_kind;
                ent_q[alloc_idx].lvl   <= alloc_lvl;
                ent_q[alloc_idx].to_i  <= alloc_to_i;
                ent_q[alloc_idx].to_d  <= alloc_to_d;
                ent_q[alloc_idx].stamp <= alloc_stamp;
            end
            if (take_ret) begin
                r_q[ret_idx]        <= 1'b1;
                ent_q[ret_idx].data <= ret_data;
                ent_q[ret_idx].fc   <= ret_cycle;
            end
            if (clr_en) begin
                v_q[clr_idx] <= 1'b0;
                r_q[clr_idx] <= 1'b0;
            end
            cnt_q <= cnt_q + CNT_W'(take_ret) - CNT_W'(clr_en);
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_out
            assign fcyc[g]    = ent_q[g].fc;
            assign rdy_vec[g] = v_q[g] && r_q[g];
        end
    endgenerate

    assign rd_addr   = ent_q[rd_idx].addr;
    assign rd_kind   = ent_q[rd_idx].kind;
    assign rd_lvl    = ent_q[rd_idx].lvl;
    assign rd_to_i   = ent_q[rd_idx].to_i;
    assign rd_to_d   = ent_q[rd_idx].to_d;
    assign rd_stamp  = ent_q[rd_idx].stamp;
    assign rd_data   = ent_q[rd_idx].data;
    assign ret_count = cnt_q;

    AST_CNT_MATCHES: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) == $countones(v_q & r_q)); // R9
    AST_CLR_READY: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> (v_q[clr_idx] && r_q[clr_idx])); // R9

endmodule

// File: rtl/fill_pick.sv
module fill_pick #(
    parameter int ENTRIES = 4,
    parameter int CYC_W   = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ENTRIES-1:0]  rdy_vec,
    input  logic [CYC_W-1:0]    fcyc [ENTRIES],
    output logic                any,
    output logic [IDX_W-1:0]    idx,
    output logic [CYC_W-1:0]    cyc
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        cyc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rdy_vec[i] && (!any || fcyc[i] < cyc)) begin
                any = 1'b1;
                idx = IDX_W'(i);
                cyc = fcyc[i];
            end
        end
    end

    AST_PICK_READY: assert property (@(posedge clk) disable iff (rst)
        any |-> rdy_vec[idx]); // R3

endmodule

// File: rtl/fill_lines.sv
module fill_lines #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  vic_set,
    input  logic [WAY_W-1:0]  vic_way,
    output logic              vic_valid,
    output logic              vic_dirty,
    output logic [TAG_W-1:0]  vic_tag,
    output logic [DATA_W-1:0] vic_data,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    input  logic [SET_W-1:0]  pb_set,
    input  logic [WAY_W-1:0]  pb_way,
    output logic              pb_valid,
    output logic              pb_dirty,
    output logic [TAG_W-1:0]  pb_tag,
    output logic [DATA_W-1:0] pb_data
);
    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t line_q [SETS][WAYS];
    line_t vic;
    line_t pb;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    line_q[s][w].valid <= 1'b0;
                    line_q[s][w].dirty <= 1'b0;
                end
            end
        end else if (wr_en) begin
            line_q[vic_set][vic_way] <= '{valid: 1'b1, dirty: wr_dirty,
                                          tag: wr_tag, data: wr_data};
        end
    end

    assign vic       = line_q[vic_set][vic_way];
    assign vic_valid = vic.valid;
    assign vic_dirty = vic.dirty;
    assign vic_tag   = vic.tag;
    assign vic_data  = vic.data;

    assign pb        = line_q[pb_set][pb_way];
    assign pb_valid  = pb.valid;
    assign pb_dirty  = pb.dirty;
    assign pb_tag    = pb.tag;
    assign pb_data   = pb.data;

endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl #(
    parameter int ENTRIES = 4,
    parameter int SETS    = 4,
    parameter int WAYS    = 2,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 16,
    parameter int CYC_W   = 16,
    parameter int IP_W    = 8,
    parameter int STALL_W = 16,
    parameter logic [fill_pkg::LVL_W-1:0] LEVEL = 4'd2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W  = ADDR_W - SET_W,
    localparam int LVL_W  = fill_pkg::LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CYC_W-1:0]   cur_cycle,
    input  logic               alloc_en,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic [ADDR_W-1:0]  alloc_addr,
    input  logic [1:0]         alloc_kind,
    input  logic [LVL_W-1:0]   alloc_lvl,
    input  logic               alloc_to_i,
    input  logic               alloc_to_d,
    input  logic [CYC_W-1:0]   alloc_stamp,
    input  logic               ret_en,
    input  logic [IDX_W-1:0]   ret_idx,
    input  logic [DATA_W-1:0]  ret_data,
    input  logic [CYC_W-1:0]   ret_cycle,
    output logic [SET_W-1:0]   fill_set,
    input  logic [WAY_W-1:0]   victim_way,
    input  logic               lwq_full,
    output logic               fill_done,
    output logic [IDX_W-1:0]   fill_idx,
    output logic [CNT_W-1:0]   ret_count,
    output logic [STALL_W-1:0] stall_count,
    output logic               wb_valid,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [DATA_W-1:0]  wb_data,
    output logic [1:0]         wb_kind,
    output logic [LVL_W-1:0]   wb_lvl,
    output logic [IP_W-1:0]    wb_ip,
    output logic               up_i_valid,
    output logic               up_d_valid,
    output logic [ADDR_W-1:0]  up_addr,
    output logic [DATA_W-1:0]  up_data,
    output logic               lat_valid,
    output logic [CYC_W-1:0]   lat_value,
    input  logic [SET_W-1:0]   pb_set,
    input  logic [WAY_W-1:0]   pb_way,
    output logic               pb_valid,
    output logic               pb_dirty,
    output logic [TAG_W-1:0]   pb_tag,
    output logic [DATA_W-1:0]  pb_data
);
    import fill_pkg::*;

    logic [ENTRIES-1:0] rdy_vec;
    logic [CYC_W-1:0]   fcyc [ENTRIES];
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [CYC_W-1:0]   pick_cyc;

    logic [ADDR_W-1:0]  e_addr;
    req_kind_e          e_kind;
    logic [LVL_W-1:0]   e_lvl;
    logic               e_to_i;
    logic               e_to_d;
    logic [CYC_W-1:0]   e_stamp;
    logic [DATA_W-1:0]  e_data;

    logic               vic_valid;
    logic               vic_dirty;
    logic [TAG_W-1:0]   vic_tag;
    logic [DATA_W-1:0]  vic_data;

    logic               due;
    logic               need_wb;
    logic               blocked;
    logic               do_fill;
    logic               go_up;

    fill_track #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W)
    ) u_track (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_addr(alloc_addr),
        .alloc_kind(req_kind_e'(alloc_kind)), .alloc_lvl(alloc_lvl),
        .alloc_to_i(alloc_to_i), .alloc_to_d(alloc_to_d), .alloc_stamp(alloc_stamp),
        .ret_en(ret_en), .ret_idx(ret_idx), .ret_data(ret_data), .ret_cycle(ret_cycle),
        .clr_en(do_fill), .clr_idx(pick_idx), .rd_idx(pick_idx),
        .rdy_vec(rdy_vec), .fcyc(fcyc),
        .rd_addr(e_addr), .rd_kind(e_kind), .rd_lvl(e_lvl),
        .rd_to_i(e_to_i), .rd_to_d(e_to_d), .rd_stamp(e_stamp), .rd_data(e_data),
        .ret_count(ret_count)
    );

    fill_pick #(.ENTRIES(ENTRIES), .CYC_W(CYC_W)) u_pick (
        .clk(clk), .rst(rst), .rdy_vec(rdy_vec), .fcyc(fcyc),
        .any(pick_any), .idx(pick_idx), .cyc(pick_cyc)
    );

    assign fill_set = e_addr[SET_W-1:0];

    fill_lines #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst(rst),
        .vic_set(fill_set), .vic_way(victim_way),
        .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_tag(vic_tag), .vic_data(vic_data),
        .wr_en(do_fill), .wr_tag(e_addr[ADDR_W-1:SET_W]), .wr_data(e_data),
        .wr_dirty(is_owned(e_kind)),
        .pb_set(pb_set), .pb_way(pb_way),
        .pb_valid(pb_valid), .pb_dirty(pb_dirty), .pb_tag(pb_tag), .pb_data(pb_data)
    );

    // Fill decision: victim state is read from the store in this same cycle,
    // before the install at the clock edge overwrites it.
    always_comb begin
        due     = pick_any && (cur_cycle >= pick_cyc);
        need_wb = vic_valid && vic_dirty;
        blocked = due && need_wb && lwq_full;
        do_fill = due && !blocked;
        go_up   = e_lvl < LEVEL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_count <= '0;
            fill_done   <= 1'b0;
            fill_idx    <= '0;
            wb_valid    <= 1'b0;
            wb_addr     <= '0;
            wb_data     <= '0;
            up_i_valid  <= 1'b0;
            up_d_valid  <= 1'b0;
            up_addr     <= '0;
            up_data     <= '0;
            lat_valid   <= 1'b0;
            lat_value   <= '0;
        end else begin
            stall_count <= stall_count + STALL_W'(blocked);
            fill_done   <= do_fill;
            fill_idx    <= pick_idx;
            wb_valid    <= do_fill && need_wb;
            wb_addr     <= {vic_tag, fill_set};
            wb_data     <= vic_data;
            up_i_valid  <= do_fill && go_up && e_to_i;
            up_d_valid  <= do_fill && go_up && e_to_d;
            up_addr     <= e_addr;
            up_data     <= e_data;
            lat_valid   <= do_fill && (e_stamp != '0);
            lat_value   <= cur_cycle - e_stamp;
        end
    end

    assign wb_kind = K_WBACK;
    assign wb_lvl  = lower_code(LEVEL);
    assign wb_ip   = '0;

    AST_WB_ROOM: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !$past(lwq_full)); // R5
    AST_STALL_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (stall_count != $past(stall_count)) |-> !fill_done); // R4
    AST_UP_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        (up_i_valid || up_d_valid) |-> fill_done); // R7
    AST_LAT_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
        lat_valid |-> fill_done); // R8

endmodule

// File: tb/sim_fill_ctrl.sv
module sim_fill_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cc = 16'd100;
    logic        alloc_en = 1'b0;
    logic [1:0]  alloc_idx = '0;
    logic [9:0]  alloc_addr = '0;
    logic [1:0]  alloc_kind = '0;
    logic [3:0]  alloc_lvl = '0;
    logic        alloc_to_i = 1'b0;
    logic        alloc_to_d = 1'b0;
    logic [15:0] alloc_stamp = '0;
    logic        ret_en = 1'b0;
    logic [1:0]  ret_idx = '0;
    logic [15:0] ret_data = '0;
    logic [15:0] ret_cycle = '0;
    logic [1:0]  fill_set;
    logic        victim_way = 1'b0;
    logic        lwq_full = 1'b0;
    logic        fill_done;
    logic [1:0]  fill_idx;
    logic [2:0]  ret_count;
    logic [15:0] stall_count;
    logic        wb_valid;
    logic [9:0]  wb_addr;
    logic [15:0] wb_data;
    logic [1:0]  wb_kind;
    logic [3:0]  wb_lvl;
    logic [7:0]  wb_ip;
    logic        up_i_valid, up_d_valid;
    logic [9:0]  up_addr;
    logic [15:0] up_data;
    logic        lat_valid;
    logic [15:0] lat_value;
    logic [1:0]  pb_set = '0;
    logic        pb_way = 1'b0;
    logic        pb_valid, pb_dirty;
    logic [7:0]  pb_tag;
    logic [15:0] pb_data;

    int vectors = 0;
    int miscompares = 0;

    // line-store model
    logic        mv   [4][2];
    logic        md   [4][2];
    logic [7:0]  mt   [4][2];
    logic [15:0] mdat [4][2];

    always #10 clk = ~clk;

    fill_ctrl u0 (
        .clk(clk), .rst(rst), .cur_cycle(cc),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_addr(alloc_addr),
        .alloc_kind(alloc_kind), .alloc_lvl(alloc_lvl), .alloc_to_i(alloc_to_i),
        .alloc_to_d(alloc_to_d), .alloc_stamp(alloc_stamp),
        .ret_en(ret_en), .ret_idx(ret_idx), .ret_data(ret_data), .ret_cycle(ret_cycle),
        .fill_set(fill_set), .victim_way(victim_way), .lwq_full(lwq_full),
        .fill_done(fill_done), .fill_idx(fill_idx), .ret_count(ret_count),
        .stall_count(stall_count),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_kind(wb_kind),
        .wb_lvl(wb_lvl), .wb_ip(wb_ip),
        .up_i_valid(up_i_valid), .up_d_valid(up_d_valid), .up_addr(up_addr),
        .up_data(up_data), .lat_valid(lat_valid), .lat_value(lat_value),
        .pb_set(pb_set), .pb_way(pb_way), .pb_valid(pb_valid), .pb_dirty(pb_dirty),
        .pb_tag(pb_tag), .pb_data(pb_data)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // allocate, return data, then set the victim way; ends at a negedge
    task automatic issue(input logic [1:0] idx, input logic [9:0] addr, input logic [1:0] kind,
                         input logic [3:0] lvl, input logic ti, input logic td,
                         input logic [15:0] stamp, input logic [15:0] data,
                         input logic [15:0] fc, input logic way);
        @(negedge clk);
        alloc_en = 1'b1; alloc_idx = idx; alloc_addr = addr; alloc_kind = kind;
        alloc_lvl = lvl; alloc_to_i = ti; alloc_to_d = td; alloc_stamp = stamp;
        @(negedge clk);
        alloc_en = 1'b0;
        ret_en = 1'b1; ret_idx = idx; ret_data = data; ret_cycle = fc;
        @(negedge clk);
        ret_en = 1'b0;
        victim_way = way;
    endtask

    // check a completed fill against the model, then update the model and probe
    task automatic chk_fill(input string tg, input logic [1:0] idx, input logic [9:0] addr,
                            input logic [1:0] kind, input logic [3:0] lvl, input logic ti,
                            input logic td, input logic [15:0] stamp, input logic [15:0] data,
                            input logic way);
        logic [1:0] s;
        logic       ev;
        s  = addr[1:0];
        ev = mv[s][way] && md[s][way];
        chk({tg, " R9 fill_done"}, 32'(fill_done), 1);
        chk({tg, " R9 fill_idx"}, 32'(fill_idx), 32'(idx));
        chk({tg, " R5 wb_valid"}, 32'(wb_valid), 32'(ev));
        if (ev) begin
            chk({tg, " R5 wb_addr"}, 32'(wb_addr), 32'({mt[s][way], s}));
            chk({tg, " R5 wb_data"}, 32'(wb_data), 32'(mdat[s][way]));
            chk({tg, " R5 wb_kind"}, 32'(wb_kind), 3);
            chk({tg, " R5 wb_lvl"}, 32'(wb_lvl), 4);
            chk({tg, " R5 wb_ip"}, 32'(wb_ip), 0);
        end
        chk({tg, " R7 up_i"}, 32'(up_i_valid), 32'((lvl < 4'd2) && ti));
        chk({tg, " R7 up_d"}, 32'(up_d_valid), 32'((lvl < 4'd2) && td));
        chk({tg, " R7 up_data"}, 32'(up_data), 32'(data));
        chk({tg, " R8 lat_valid"}, 32'(lat_valid), 32'(stamp != 0));
        if (stamp != 0) chk({tg, " R8 lat_value"}, 32'(lat_value), 32'(16'(cc - stamp)));
        mv[s][way] = 1'b1; md[s][way] = (kind == 2'd1);
        mt[s][way] = addr[9:2]; mdat[s][way] = data;
        pb_set = s; pb_way = way;
        #1;
        chk({tg, " R6 valid"}, 32'(pb_valid), 1);
        chk({tg, " R6 dirty"}, 32'(pb_dirty), 32'(kind == 2'd1));
        chk({tg, " R6 tag"}, 32'(pb_tag), 32'(addr[9:2]));
        chk({tg, " R6 data"}, 32'(pb_data), 32'(data));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [9:0]  a;
        logic [15:0] d;
        logic [15:0] st;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                mv[s][w] = 1'b0; md[s][w] = 1'b0; mt[s][w] = '0; mdat[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ret_count", 32'(ret_count), 0);
        chk("R1 stall_count", 32'(stall_count), 0);
        chk("R1 outputs", 32'({fill_done, wb_valid, up_i_valid, up_d_valid, lat_valid}), 0);
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                pb_set = 2'(s); pb_way = w[0];
                #1 chk("R1 line invalid", 32'(pb_valid), 0);
            end

        // sweep A: ownership fills into every empty slot
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                a  = {8'(8'h10 + s * 2 + w), 2'(s)};
                d  = 16'(16'hA000 + s * 16 + w);
                st = 16'(s * 2 + w + 1);
                issue(2'(s * 2 + w), a, 2'd1, 4'd1, s[0], w[0], st, d, cc, w[0]);
                @(negedge clk);
                chk_fill("sweepA", 2'(s * 2 + w), a, 2'd1, 4'd1, s[0], w[0], st, d, w[0]);
            end

        // sweep B: clean fills evicting the dirty lines, no upward return
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                a = {8'(8'h80 + s * 2 + w), 2'(s)};
                d = 16'(16'h5000 + s * 32 + w * 3);
                issue(2'(s + w), a, s[0] ? 2'd2 : 2'd0, 4'd2, 1'b1, 1'b1, 16'd0, d, cc, w[0]);
                @(negedge clk);
                chk_fill("sweepB", 2'(s + w), a, s[0] ? 2'd2 : 2'd0, 4'd2, 1'b1, 1'b1, 16'd0, d, w[0]);
            end

        // clean victim: no writeback (R5)
        issue(2'd3, {8'h33, 2'd2}, 2'd0, 4'd0, 1'b0, 1'b1, 16'd7, 16'h1234, cc, 1'b1);
        @(negedge clk);
        chk_fill("clean", 2'd3, {8'h33, 2'd2}, 2'd0, 4'd0, 1'b0, 1'b1, 16'd7, 16'h1234, 1'b1);

        // R4 stall: make set 0 way 0 dirty, then fill over it with queue full
        issue(2'd0, {8'h44, 2'd0}, 2'd1, 4'd3, 1'b0, 1'b0, 16'd9, 16'hBEEF, cc, 1'b0);
        @(negedge clk);
        chk_fill("stall-prep", 2'd0, {8'h44, 2'd0}, 2'd1, 4'd3, 1'b0, 1'b0, 16'd9, 16'hBEEF, 1'b0);
        lwq_full = 1'b1;
        issue(2'd1, {8'h55, 2'd0}, 2'd0, 4'd1, 1'b1, 1'b0, 16'd3, 16'hC0DE, cc, 1'b0);
        @(negedge clk);
        chk("R4 no fill", 32'(fill_done), 0);
        chk("R4 stall 1", 32'(stall_count), 1);
        chk("R4 entry kept", 32'(ret_count), 1);
        @(negedge clk);
        chk("R4 stall 2", 32'(stall_count), 2);
        pb_set = 2'd0; pb_way = 1'b0;
        #1 chk("R4 line unchanged", 32'(pb_tag), 32'h44);
        lwq_full = 1'b0;
        @(negedge clk);
        chk_fill("stall-release", 2'd1, {8'h55, 2'd0}, 2'd0, 4'd1, 1'b1, 1'b0, 16'd3, 16'hC0DE, 1'b0);
        chk("R4 stall stops", 32'(stall_count), 2);
        chk("R9 count after", 32'(ret_count), 0);

        // R2 gating on fill cycle
        issue(2'd2, {8'h66, 2'd1}, 2'd0, 4'd1, 1'b1, 1'b1, 16'd50, 16'h7777, 16'(cc + 3), 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 not yet due", 32'(fill_done), 0);
        end
        cc = 16'(cc + 2);
        @(negedge clk);
        chk("R2 one below due", 32'(fill_done), 0);
        cc = 16'(cc + 1);
        @(negedge clk);
        chk_fill("gate", 2'd2, {8'h66, 2'd1}, 2'd0, 4'd1, 1'b1, 1'b1, 16'd50, 16'h7777, 1'b0);

        // R3 pick order: index 1 and 2 tie at 50, index 0 at 70
        cc = 16'd40;
        issue(2'd0, {8'h71, 2'd3}, 2'd1, 4'd1, 1'b0, 1'b1, 16'd10, 16'h0A0A, 16'd70, 1'b0);
        issue(2'd2, {8'h72, 2'd2}, 2'd0, 4'd1, 1'b1, 1'b0, 16'd20, 16'h0B0B, 16'd50, 1'b0);
        issue(2'd1, {8'h73, 2'd1}, 2'd0, 4'd2, 1'b1, 1'b1, 16'd30, 16'h0C0C, 16'd50, 1'b0);
        @(negedge clk);
        chk("R3 none early", 32'(fill_done), 0);
        chk("R9 three pending", 32'(ret_count), 3);
        cc = 16'd100;
        @(negedge clk);
        chk_fill("order1", 2'd1, {8'h73, 2'd1}, 2'd0, 4'd2, 1'b1, 1'b1, 16'd30, 16'h0C0C, 1'b0);
        chk("R9 two pending", 32'(ret_count), 2);
        @(negedge clk);
        chk_fill("order2", 2'd2, {8'h72, 2'd2}, 2'd0, 4'd1, 1'b1, 1'b0, 16'd20, 16'h0B0B, 1'b0);
        @(negedge clk);
        chk_fill("order3", 2'd0, {8'h71, 2'd3}, 2'd1, 4'd1, 1'b0, 1'b1, 16'd10, 16'h0A0A, 1'b0);
        chk("R9 none pending", 32'(ret_count), 0);
        @(negedge clk);
        chk("R9 single pulse", 32'(fill_done), 0);

        summary();
        $finish;
    end
endmodule